// File: doc/BRIEF.md
# VITC read line scan controller

This block chooses, field by field, which video line a vertical interval time code reader samples, for two redundant read slots. Each slot is programmed with a 5-bit line code and an enable. A code from 0 to 30 pins the slot to one line, the code plus 10 (lines 10 to 40). The code 31 (1Fh) puts the slot into automatic search instead. The controller watches the current line number, a field-start strobe and an end-of-line strobe. At each end of line it takes the result of an external bit decoder, which reports whether the code word was complete and whether its CRC was good.

A searching slot walks line by line from its start line until it sees a qualified word or until line 41 has been tried. The second slot's search is chained to the first. It starts at line 10 when the first slot is disabled. It starts on the line after the first slot's fixed line when that slot is fixed. It waits for the first slot's find when both slots search. Each slot exposes two status flags, a missing-code flag and a CRC-error flag, plus the line it is currently trying. It also drives a strobe that tells the reader to sample the present line. Mode and line code are taken at each field start, so software may rewrite them between fields to sweep for code.

Top module: `vitc_read_scan`

## Requirements
- R1: With line code N in 0..30, the slot's sample strobe is high only while the current line equals N+10, and the tried-line output reads N+10 during that field; the tried-line output is always 0 or within 10..41.
- R2: At the end of its fixed line, a slot sets its missing-code flag to the inverse of the decoder's complete input, and its CRC-error flag to 1 unless the decoder reported both complete and CRC good. The two flags change only in a cycle following an end-of-line strobe.
- R3: Line code 31 on slot 1 makes it search from line 10 upward. It stops at the first line whose word is complete with good CRC, clears both flags and leaves the tried-line output on that line. A slot's flags become both zero only after an end of line that carried such a word.
- R4: A search that tries line 41 without a qualified word sets both flags to 1 and leaves the tried-line output at 41.
- R5: When both slots search, slot 2 samples nothing until slot 1 finds a word on line L, then searches from L+1; if L is 41, slot 2 ends the field at once with both flags 1 and tried line 41, sampling no line.
- R6: When slot 1 is fixed on line F and slot 2 searches, slot 2 starts at line F+1, whatever slot 1 received.
- R7: When slot 1 is disabled, a searching slot 2 starts at line 10. When slot 1's search fails, a waiting slot 2 fails in the same end-of-line cycle without sampling any line.
- R8: A slot with its enable low never raises its sample strobe, and its flags keep their values.
- R9: After reset both flags of each slot are 1, the tried lines are 0 and no sample strobe is high.
- R10: Every field start restarts each slot from its start line with the mode and line code present at that moment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_line_cfg | input | 2x5 | Per-slot line code; 31 selects search, else line = code + 10 |
| i_enable | input | 2 | Per-slot enable (bit 0 is slot 1) |
| i_line | input | 9 | Current video line number |
| i_field_start | input | 1 | One-cycle strobe at the start of each field |
| i_eol | input | 1 | One-cycle strobe at the end of the line in i_line |
| i_dec_complete | input | 1 | Decoder: all code bits received on this line (valid with i_eol) |
| i_dec_crc_ok | input | 1 | Decoder: CRC matched on this line (valid with i_eol) |
| o_sample | output | 2 | Per-slot strobe: sample the present line |
| o_try_line | output | 2x9 | Per-slot line being tried or last tried |
| o_crc_err | output | 2 | Per-slot CRC-error flag (0 = qualified CRC) |
| o_no_code | output | 2 | Per-slot missing-code flag (1 = framing error or nothing found) |

## Verification
The hardest case to reach from the ports is the handover at the end of the range. Slot 1's search succeeds on line 41 itself, and slot 2, chained to it, must fail without sampling anything. A slot 1 fixed on line 40 must hand slot 2 exactly one line. The sweep reaches these cases with a decoder pattern whose only qualified word sits on line 41, and with line code 30 on slot 1. It crosses every decoder pattern with every pair of slot codes and every enable combination, field after field, so flag values carried over from earlier fields are also exercised.

// File: rtl/vitc_scan_pkg.sv
package vitc_scan_pkg;

    localparam int CFG_W     = 5;
    localparam int LINE_W    = 9;
    localparam int NUM_SLOTS = 2;

    typedef logic [CFG_W-1:0]  cfg_t;
    typedef logic [LINE_W-1:0] line_t;

    localparam cfg_t SCAN_CODE = cfg_t'(5'h1F);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_TRY  = 2'd2,
        ST_DONE = 2'd3
    } slot_state_e;

    typedef struct packed {
        logic  search;
        line_t line;
    } slot_mode_t;

    typedef struct packed {
        logic crc_err;
        logic no_code;
    } slot_flags_t;

    localparam slot_flags_t FLAGS_NONE = '{crc_err: 1'b1, no_code: 1'b1};
    localparam slot_flags_t FLAGS_OK   = '{crc_err: 1'b0, no_code: 1'b0};

    function automatic slot_flags_t grade(input logic complete, input logic crc_ok);
        slot_flags_t f;
        f.no_code = ~complete;
        f.crc_err = ~(complete & crc_ok);
        return f;
    endfunction

endpackage

// File: rtl/vitc_line_map.sv
module vitc_line_map
    import vitc_scan_pkg::*;
#(
    parameter int LINE_OFS = 10
) (
    input  cfg_t       i_raw,
    output slot_mode_t o_mode
);
    always_comb begin
        o_mode.search = (i_raw == SCAN_CODE);
        o_mode.line   = line_t'(i_raw) + line_t'(LINE_OFS);
    end
endmodule

// File: rtl/vitc_scan_chain.sv
module vitc_scan_chain
    import vitc_scan_pkg::*;
#(
    parameter int LINE_OFS = 10,
    parameter int LINE_END = 41
) (
    input  logic       i_prev_enable,
    input  slot_mode_t i_prev_mode,
    input  logic       i_prev_found,
    input  line_t      i_prev_found_line,
    input  logic       i_prev_fail,
    output logic       o_wait,
    output line_t      o_start_line,
    output logic       o_kick,
    output line_t      o_kick_line,
    output logic       o_kick_fail
);
    logic prev_at_end;

    always_comb begin
        prev_at_end  = (i_prev_found_line == line_t'(LINE_END));
        o_wait       = i_prev_enable & i_prev_mode.search;
        o_start_line = (i_prev_enable && !i_prev_mode.search)
                       ? i_prev_mode.line + line_t'(1)
                       : line_t'(LINE_OFS);
        o_kick       = i_prev_found & ~prev_at_end;
        o_kick_line  = i_prev_found_line + line_t'(1);
        o_kick_fail  = i_prev_fail | (i_prev_found & prev_at_end);
    end
endmodule

// File: rtl/vitc_slot.sv
module vitc_slot
    import vitc_scan_pkg::*;
#(
    parameter int LINE_END = 41
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        i_enable,
    input  slot_mode_t  i_mode,
    input  logic        i_field_start,
    input  logic        i_eol,
    input  line_t       i_line,
    input  logic        i_complete,
    input  logic        i_crc_ok,
    input  logic        i_chain_wait,
    input  line_t       i_start_line,
    input  logic        i_kick,
    input  line_t       i_kick_line,
    input  logic        i_kick_fail,
    output logic        o_active,
    output line_t       o_try_line,
    output slot_flags_t o_flags,
    output logic        o_found,
    output line_t       o_found_line,
    output logic        o_fail
);
    slot_state_e state_q;
    line_t       try_q;
    logic        search_q;
    slot_flags_t flags_q;

    logic hit;
    logic qual;
    logic at_end;

    always_comb begin
        o_active     = i_enable && (state_q == ST_TRY) && (i_line == try_q);
        hit          = o_active && i_eol;
        qual         = i_complete && i_crc_ok;
        at_end       = (try_q == line_t'(LINE_END));
        o_found      = hit && search_q && qual;
        o_fail       = hit && search_q && !qual && at_end;
        o_found_line = try_q;
        o_try_line   = try_q;
        o_flags      = flags_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            try_q    <= '0;
            search_q <= 1'b0;
            flags_q  <= FLAGS_NONE;
        end else if (i_field_start) begin
            search_q <= i_mode.search;
            if (i_mode.search) begin
                try_q   <= i_start_line;
                state_q <= i_chain_wait ? ST_WAIT : ST_TRY;
            end else begin
                try_q   <= i_mode.line;
                state_q <= ST_TRY;
            end
        end else if (i_enable) begin
            case (state_q)
                ST_TRY: begin
                    if (hit) begin
                        if (!search_q) begin
                            flags_q <= grade(i_complete, i_crc_ok);
                            state_q <= ST_DONE;
                        end else if (qual) begin
                            flags_q <= FLAGS_OK;
                            state_q <= ST_DONE;
                        end else if (at_end) begin
                            flags_q <= FLAGS_NONE;
                            state_q <= ST_DONE;
                        end else begin
                            try_q <= try_q + line_t'(1);
                        end
                    end
                end
                ST_WAIT: begin
                    if (i_kick_fail) begin
                        flags_q <= FLAGS_NONE;
                        try_q   <= line_t'(LINE_END);
                        state_q <= ST_DONE;
                    end else if (i_kick) begin
                        try_q   <= i_kick_line;
                        state_q <= ST_TRY;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/vitc_read_scan.sv
module vitc_read_scan
    import vitc_scan_pkg::*;
#(
    parameter int LINE_OFS = 10,
    parameter int LINE_END = 41
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic [NUM_SLOTS-1:0][CFG_W-1:0]    i_line_cfg,
    input  logic [NUM_SLOTS-1:0]               i_enable,
    input  logic [LINE_W-1:0]                  i_line,
    input  logic                               i_field_start,
    input  logic                               i_eol,
    input  logic                               i_dec_complete,
    input  logic                               i_dec_crc_ok,
    output logic [NUM_SLOTS-1:0]               o_sample,
    output logic [NUM_SLOTS-1:0][LINE_W-1:0]   o_try_line,
    output logic [NUM_SLOTS-1:0]               o_crc_err,
    output logic [NUM_SLOTS-1:0]               o_no_code
);
    slot_mode_t  mode_v      [NUM_SLOTS];
    slot_flags_t flags_v     [NUM_SLOTS];
    line_t       try_v       [NUM_SLOTS];
    logic        found_v     [NUM_SLOTS];
    line_t       found_ln_v  [NUM_SLOTS];
    logic        fail_v      [NUM_SLOTS];
    logic        wait_v      [NUM_SLOTS];
    line_t       start_v     [NUM_SLOTS];
    logic        kick_v      [NUM_SLOTS];
    line_t       kick_ln_v   [NUM_SLOTS];
    logic        kick_fail_v [NUM_SLOTS];

    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
        vitc_line_map #(.LINE_OFS(LINE_OFS)) u_map (
            .i_raw  (i_line_cfg[k]),
            .o_mode (mode_v[k])
        );

        if (k == 0) begin : g_head
            assign wait_v[k]      = 1'b0;
            assign start_v[k]     = line_t'(LINE_OFS);
            assign kick_v[k]      = 1'b0;
            assign kick_ln_v[k]   = '0;
            assign kick_fail_v[k] = 1'b0;
        end else begin : g_chained
            vitc_scan_chain #(.LINE_OFS(LINE_OFS), .LINE_END(LINE_END)) u_chain (
                .i_prev_enable     (i_enable[k-1]),
                .i_prev_mode       (mode_v[k-1]),
                .i_prev_found      (found_v[k-1]),
                .i_prev_found_line (found_ln_v[k-1]),
                .i_prev_fail       (fail_v[k-1]),
                .o_wait            (wait_v[k]),
                .o_start_line      (start_v[k]),
                .o_kick            (kick_v[k]),
                .o_kick_line       (kick_ln_v[k]),
                .o_kick_fail       (kick_fail_v[k])
            );
        end

        vitc_slot #(.LINE_END(LINE_END)) u_slot (
            .clk           (clk),
            .rst           (rst),
            .i_enable      (i_enable[k]),
            .i_mode        (mode_v[k]),
            .i_field_start (i_field_start),
            .i_eol         (i_eol),
            .i_line        (i_line),
            .i_complete    (i_dec_complete),
            .i_crc_ok      (i_dec_crc_ok),
            .i_chain_wait  (wait_v[k]),
            .i_start_line  (start_v[k]),
            .i_kick        (kick_v[k]),
            .i_kick_line   (kick_ln_v[k]),
            .i_kick_fail   (kick_fail_v[k]),
            .o_active      (o_sample[k]),
            .o_try_line    (try_v[k]),
            .o_flags       (flags_v[k]),
            .o_found       (found_v[k]),
            .o_found_line  (found_ln_v[k]),
            .o_fail        (fail_v[k])
        );

        assign o_try_line[k] = try_v[k];
        assign o_crc_err[k]  = flags_v[k].crc_err;
        assign o_no_code[k]  = flags_v[k].no_code;
    end
endmodule

// File: rtl/vitc_read_scan_chk.sv
module vitc_read_scan_chk
    import vitc_scan_pkg::*;
#(
    parameter int LINE_OFS = 10,
    parameter int LINE_END = 41
) (
    input logic                             clk,
    input logic                             rst,
    input logic [NUM_SLOTS-1:0]             i_enable,
    input logic [LINE_W-1:0]                i_line,
    input logic                             i_eol,
    input logic                             i_dec_complete,
    input logic                             i_dec_crc_ok,
    input logic [NUM_SLOTS-1:0]             o_sample,
    input logic [NUM_SLOTS-1:0][LINE_W-1:0] o_try_line,
    input logic [NUM_SLOTS-1:0]             o_crc_err,
    input logic [NUM_SLOTS-1:0]             o_no_code
);
    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_chk
        AST_SAMPLE_ON_TRIED_LINE: assert property (@(posedge clk) disable iff (rst)
            o_sample[k] |-> (i_line == o_try_line[k])); // R1

        AST_TRIED_LINE_RANGE: assert property (@(posedge clk) disable iff (rst)
            (o_try_line[k] == '0) ||
            ((o_try_line[k] >= LINE_W'(LINE_OFS)) && (o_try_line[k] <= LINE_W'(LINE_END)))); // R1

        AST_FLAGS_ONLY_AFTER_EOL: assert property (@(posedge clk) disable iff (rst)
            !i_eol |=> $stable({o_crc_err[k], o_no_code[k]})); // R2

        AST_NOCODE_IMPLIES_CRCERR: assert property (@(posedge clk) disable iff (rst)
            o_no_code[k] |-> o_crc_err[k]); // R2

        AST_CLEAR_NEEDS_VALID_WORD: assert property (@(posedge clk) disable iff (rst)
            ((o_crc_err[k] || o_no_code[k]) && !(i_eol && i_dec_complete && i_dec_crc_ok))
            |=> (o_crc_err[k] || o_no_code[k])); // R3

        AST_DISABLED_NO_SAMPLE: assert property (@(posedge clk) disable iff (rst)
            !i_enable[k] |-> !o_sample[k]); // R8

        AST_DISABLED_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
            !i_enable[k] |=> $stable({o_crc_err[k], o_no_code[k]})); // R8
    end
endmodule

bind vitc_read_scan vitc_read_scan_chk #(.LINE_OFS(LINE_OFS), .LINE_END(LINE_END)) u_vitc_read_scan_chk (
    .clk            (clk),
    .rst            (rst),
    .i_enable       (i_enable),
    .i_line         (i_line),
    .i_eol          (i_eol),
    .i_dec_complete (i_dec_complete),
    .i_dec_crc_ok   (i_dec_crc_ok),
    .o_sample       (o_sample),
    .o_try_line     (o_try_line),
    .o_crc_err      (o_crc_err),
    .o_no_code      (o_no_code)
);

// File: tb/test_vitc_read_scan.sv
module test_vitc_read_scan;
    import vitc_scan_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic                             rst;
    logic [NUM_SLOTS-1:0][CFG_W-1:0]  line_cfg;
    logic [NUM_SLOTS-1:0]             enable;
    logic [LINE_W-1:0]                line;
    logic                             field_start;
    logic                             eol;
    logic                             dec_complete;
    logic                             dec_crc_ok;
    logic [NUM_SLOTS-1:0]             sample;
    logic [NUM_SLOTS-1:0][LINE_W-1:0] try_line;
    logic [NUM_SLOTS-1:0]             crc_err;
    logic [NUM_SLOTS-1:0]             no_code;

    vitc_read_scan i_vitc_read_scan (
        .clk            (clk),
        .rst            (rst),
        .i_line_cfg     (line_cfg),
        .i_enable       (enable),
        .i_line         (line),
        .i_field_start  (field_start),
        .i_eol          (eol),
        .i_dec_complete (dec_complete),
        .i_dec_crc_ok   (dec_crc_ok),
        .o_sample       (sample),
        .o_try_line     (try_line),
        .o_crc_err      (crc_err),
        .o_no_code      (no_code)
    );

    int  checks   = 0;
    int  failures = 0;
    int  cycles   = 0;
    bit  finished = 0;

    int first_l [2];
    int last_l  [2];
    int cnt_l   [2];
    int exp_ce  [2];
    int exp_nc  [2];

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000 && !finished) begin
            finished = 1;
            failures++;
            checks++;
            $display("FAIL watchdog (all) actual=%0d expected<200000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // decoder patterns: which lines carry a complete word / a good CRC
    function automatic bit pat_comp(input int p, input int l);
        case (p)
            0: return (l == 15) || (l == 20);
            1: return (l == 10) || (l == 30);
            2: return (l == 12) || (l == 41);
            default: return (l == 25);
        endcase
    endfunction

    function automatic bit pat_crc(input int p, input int l);
        case (p)
            0: return (l == 20) || (l == 33);
            1: return (l == 10) || (l == 30);
            2: return (l == 41);
            default: return 1'b0;
        endcase
    endfunction

    function automatic bit pat_qual(input int p, input int l);
        return pat_comp(p, l) && pat_crc(p, l);
    endfunction

    // search model: start s, result first/last sampled line and success
    task automatic scan(input int p, input int s, output int f, output int l, output bit ok);
        ok = 0;
        if (s > 41) begin
            f = -1; l = -1;
            return;
        end
        f = s; l = 41;
        for (int x = s; x <= 41; x++) begin
            if (pat_qual(p, x)) begin
                l = x; ok = 1;
                return;
            end
        end
    endtask

    task automatic run_field(input int p, input int c1, input int c2, input int en);
        @(negedge clk);
        line_cfg[0] = CFG_W'(c1);
        line_cfg[1] = CFG_W'(c2);
        enable      = NUM_SLOTS'(en);
        field_start = 1'b1;
        line        = '0;
        eol         = 1'b0;
        @(negedge clk);
        field_start = 1'b0;
        for (int k = 0; k < 2; k++) begin
            first_l[k] = -1; last_l[k] = -1; cnt_l[k] = 0;
        end
        for (int l = 1; l <= 47; l++) begin
            line         = LINE_W'(l);
            dec_complete = pat_comp(p, l);
            dec_crc_ok   = pat_crc(p, l);
            eol          = 1'b0;
            @(negedge clk);
            for (int k = 0; k < 2; k++) begin
                if (sample[k]) begin
                    cnt_l[k]++;
                    if (first_l[k] < 0) first_l[k] = l;
                    last_l[k] = l;
                end
            end
            eol = 1'b1;
            @(negedge clk);
        end
        eol = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        int cfgs [5];
        cfgs[0] = 31; cfgs[1] = 0; cfgs[2] = 5; cfgs[3] = 30; cfgs[4] = 15;

        rst = 1'b1;
        line_cfg = '0; enable = '0; line = '0;
        field_start = 1'b0; eol = 1'b0; dec_complete = 1'b0; dec_crc_ok = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R9", "crc_err", int'(crc_err), 3);
        chk("R9", "no_code", int'(no_code), 3);
        chk("R9", "try_line0", int'(try_line[0]), 0);
        chk("R9", "try_line1", int'(try_line[1]), 0);
        chk("R9", "sample", int'(sample), 0);
        for (int k = 0; k < 2; k++) begin
            exp_ce[k] = 1; exp_nc[k] = 1;
        end

        for (int p = 0; p < 4; p++)
        for (int a = 0; a < 5; a++)
        for (int b = 0; b < 5; b++)
        for (int e = 1; e <= 3; e++) begin
            int  c1, c2, l1_line;
            int  ef [2];
            int  el [2];
            int  et [2];
            bit  ok;
            bit  s1_found;
            string tg [2];
            c1 = cfgs[a]; c2 = cfgs[b];
            run_field(p, c1, c2, e);

            // slot 1 model
            s1_found = 0; l1_line = 0;
            if (c1 == 31) begin
                scan(p, 10, ef[0], el[0], ok);
                et[0] = el[0]; tg[0] = ok ? "R3" : "R4";
                if ((e & 1) != 0) begin
                    exp_ce[0] = ok ? 0 : 1; exp_nc[0] = ok ? 0 : 1;
                end
                s1_found = ok; l1_line = el[0];
            end else begin
                ef[0] = c1 + 10; el[0] = ef[0]; et[0] = ef[0]; tg[0] = "R1";
                if ((e & 1) != 0) begin
                    exp_ce[0] = pat_qual(p, ef[0]) ? 0 : 1;
                    exp_nc[0] = pat_comp(p, ef[0]) ? 0 : 1;
                end
            end

            // slot 2 model
            if (c2 != 31) begin
                ef[1] = c2 + 10; el[1] = ef[1]; et[1] = ef[1]; tg[1] = "R2";
                if ((e & 2) != 0) begin
                    exp_ce[1] = pat_qual(p, ef[1]) ? 0 : 1;
                    exp_nc[1] = pat_comp(p, ef[1]) ? 0 : 1;
                end
            end else begin
                int s;
                bit chain_fail;
                chain_fail = 0;
                if ((e & 1) != 0 && c1 == 31) begin
                    if (s1_found && l1_line < 41) begin
                        s = l1_line + 1; tg[1] = "R5";
                    end else begin
                        s = 99; chain_fail = 1; tg[1] = s1_found ? "R5" : "R7";
                    end
                end else if ((e & 1) != 0) begin
                    s = c1 + 11; tg[1] = "R6";
                end else begin
                    s = 10; tg[1] = "R7";
                end
                scan(p, s, ef[1], el[1], ok);
                et[1] = chain_fail ? 41 : el[1];
                if (!ok && !chain_fail) tg[1] = "R4";
                if ((e & 2) != 0) begin
                    exp_ce[1] = ok ? 0 : 1; exp_nc[1] = ok ? 0 : 1;
                end
            end

            for (int k = 0; k < 2; k++) begin
                if ((e & (1 << k)) != 0) begin
                    chk(tg[k], $sformatf("p%0d c%0d/%0d s%0d first", p, c1, c2, k), first_l[k], ef[k]);
                    chk(tg[k], $sformatf("p%0d c%0d/%0d s%0d last", p, c1, c2, k), last_l[k], el[k]);
                    chk(tg[k], $sformatf("p%0d c%0d/%0d s%0d try", p, c1, c2, k), int'(try_line[k]), et[k]);
                    chk(tg[k], $sformatf("p%0d c%0d/%0d s%0d crc_err", p, c1, c2, k), int'(crc_err[k]), exp_ce[k]);
                    chk(tg[k], $sformatf("p%0d c%0d/%0d s%0d no_code", p, c1, c2, k), int'(no_code[k]), exp_nc[k]);
                    if (k == 0 && c1 == 31)
                        chk("R10", $sformatf("p%0d restart from line 10", p), first_l[0], 10);
                end else begin
                    chk("R8", $sformatf("p%0d s%0d disabled samples", p, k), cnt_l[k], 0);
                    chk("R8", $sformatf("p%0d s%0d disabled crc_err", p, k), int'(crc_err[k]), exp_ce[k]);
                    chk("R8", $sformatf("p%0d s%0d disabled no_code", p, k), int'(no_code[k]), exp_nc[k]);
                end
            end
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule